// File: doc/BRIEF.md
# Two-Stage SPI Serial Clock Generator

This block derives the serial clock of an SPI controller from the bus clock. The divide ratio is the product of two programmable stages. The first is an even-only prescale byte. The second is (1 + rate), where rate is a byte. A prescale P and a rate R give one SCLK period every P × (1 + R) bus cycles, so each half period lasts (P / 2) × (1 + R) cycles.

The shift engine holds a run request while it has a frame pending or in progress. While the block is enabled and the request is high, SCLK toggles. It marks each departure from the idle level with a one-cycle leading strobe and each return to it with a one-cycle trailing strobe. The shift engine drives and samples data on these strobes. At other times SCLK rests at the level chosen by the polarity bit.

The divider values and the polarity are captured when a frame starts. A frame stops only with SCLK back at its idle level.

Top module: `spi_sclk_gen`

## Requirements
- R1: During an uninterrupted frame, successive leading strobes are exactly 2·H bus cycles apart, and each trailing strobe comes H cycles after its leading strobe. H = max(1, floor(prescale/2)) × (1 + rate).
- R2: A prescale of 2 with a rate of 1 gives an SCLK period of 4 bus cycles (H = 2).
- R3: An odd prescale acts as the next lower even value, and a prescale of 0 or 1 acts as 2. Prescale 0, 1 and 2 all give H = 1 + rate, and prescale 3 behaves like 2.
- R4: When no frame is active, SCLK equals the polarity input (0 = idle low, 1 = idle high) and both strobes are low. This holds during and after reset.
- R5: If enable and run are both high at a rising edge while no frame is active, the first leading strobe is seen H rising edges after that edge.
- R6: Each strobe lasts exactly one bus cycle. In a leading strobe cycle SCLK is the inverse of the captured polarity; in a trailing strobe cycle SCLK equals it.
- R7: SCLK does not toggle while enable or run is low, and no leading strobe follows a low enable. If run or enable falls while SCLK is away from idle, the trailing edge still comes at its normal time and no further leading edge follows.
- R8: A change to prescale, rate or polarity during a frame has no effect until the next frame start, which uses the new values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Block enable |
| prescale | input | W_PRE (8) | First-stage divisor; even, 2 to 254 |
| rate | input | W_RATE (8) | Second-stage value; divides by 1 + rate |
| cpol | input | 1 | Idle level of SCLK |
| run | input | 1 | Frame pending or in progress, from the shift engine |
| sclk | output | 1 | Serial clock pin level |
| lead_pulse | output | 1 | One-cycle strobe on the edge leaving idle |
| trail_pulse | output | 1 | One-cycle strobe on the edge returning to idle |

## Verification
Directed frames use prescale 2 with rate 1 to check the quarter-rate case. They use prescale 0, 1, 3 and 255 to show that rounding and clamping give the same half periods as the even neighbours. A large prescale with a large rate exercises counter widths that small values leave untouched. Random prescale and rate pairs at both polarities then check the first-edge delay, the half period and the full period together, which separates errors in the first stage from errors in the second. Each frame changes the divider values mid-frame and then drops run. This shows that captured values hold and that the stop is clean. A dropped enable and idle periods with polarity changes show that the clock stays still.

// File: rtl/spi_sclk_pkg.sv
package spi_sclk_pkg;

    // Which half of the SCLK cycle the generator is in.
    typedef enum logic {
        PH_IDLE = 1'b0,   // SCLK at its idle level
        PH_AWAY = 1'b1    // SCLK at the opposite level
    } sclk_phase_e;

endpackage

// File: rtl/spi_sclk_prescale_stage.sv
// First divide stage: emits a one-cycle tick every `limit` cycles while run is high.
module spi_sclk_prescale_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         run,
    input  logic [W-1:0] limit,
    output logic         tick
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    assign tick = run && (cnt_q == (limit - ONE));

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (run) begin
            cnt_d = tick ? '0 : (cnt_q + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_sclk_rate_stage.sv
// Second divide stage: counts first-stage ticks and flags the last of (limit + 1).
module spi_sclk_rate_stage #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         tick_in,
    input  logic [W-1:0] limit,
    output logic         half_done
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d, cnt_q;

    assign half_done = tick_in && (cnt_q == limit);

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (tick_in) begin
            cnt_d = half_done ? '0 : (cnt_q + ONE);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_sclk_gen.sv
// Two-stage SPI serial clock generator with leading / trailing edge strobes.
module spi_sclk_gen
    import spi_sclk_pkg::*;
#(
    parameter int W_PRE  = 8,
    parameter int W_RATE = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [W_PRE-1:0]  prescale,
    input  logic [W_RATE-1:0] rate,
    input  logic              cpol,
    input  logic              run,
    output logic              sclk,
    output logic              lead_pulse,
    output logic              trail_pulse
);
    localparam logic [W_PRE-1:0] PRE_ONE = {{(W_PRE-1){1'b0}}, 1'b1};

    typedef struct packed {
        logic              active;    // a frame is being clocked
        sclk_phase_e       phase;
        logic              pol;       // polarity captured at frame start
        logic [W_PRE-1:0]  pre_half;  // prescale / 2, at least 1
        logic [W_RATE-1:0] rate;      // rate captured at frame start
        logic              lead;
        logic              trail;
    } gen_state_t;

    gen_state_t st_d, st_q;

    // Prescale rounding: drop bit 0, clamp 0 and 1 up to 2 (half = 1).
    logic [W_PRE-1:0] pre_half_in;
    assign pre_half_in = (prescale[W_PRE-1:1] == '0) ? PRE_ONE : (prescale >> 1);

    logic stop_req;
    assign stop_req = !en || !run;

    logic cnt_clr, pre_tick, half_done;
    assign cnt_clr = !st_q.active;

    spi_sclk_prescale_stage #(.W(W_PRE)) pre_stage_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .run   (st_q.active),
        .limit (st_q.pre_half),
        .tick  (pre_tick)
    );

    spi_sclk_rate_stage #(.W(W_RATE)) rate_stage_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (cnt_clr),
        .tick_in   (pre_tick),
        .limit     (st_q.rate),
        .half_done (half_done)
    );

    always_comb begin
        st_d       = st_q;
        st_d.lead  = 1'b0;
        st_d.trail = 1'b0;
        if (!st_q.active) begin
            if (!stop_req) begin
                st_d.active   = 1'b1;
                st_d.phase    = PH_IDLE;
                st_d.pol      = cpol;
                st_d.pre_half = pre_half_in;
                st_d.rate     = rate;
            end
        end else if ((st_q.phase == PH_IDLE) && stop_req) begin
            // Clean stop: only ever leave with SCLK at its idle level.
            st_d.active = 1'b0;
        end else if (half_done) begin
            if (st_q.phase == PH_IDLE) begin
                st_d.phase = PH_AWAY;
                st_d.lead  = 1'b1;
            end else begin
                st_d.phase = PH_IDLE;
                st_d.trail = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{active: 1'b0, phase: PH_IDLE, pol: 1'b0,
                      pre_half: PRE_ONE, rate: '0, lead: 1'b0, trail: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    logic frame_active;
    assign frame_active = st_q.active;

    assign sclk        = st_q.active ? (st_q.pol ^ (st_q.phase == PH_AWAY)) : cpol;
    assign lead_pulse  = st_q.lead;
    assign trail_pulse = st_q.trail;

endmodule

// File: rtl/spi_sclk_gen_chk.sv
// Temporal checks on the clock generator, attached by bind.
module spi_sclk_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic en,
    input logic sclk,
    input logic lead_pulse,
    input logic trail_pulse,
    input logic frame_active
);

    // R6: strobes last a single cycle
    a_r6_lead_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |=> !lead_pulse);

    a_r6_trail_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |=> !trail_pulse);

    // R6: each strobe coincides with an actual SCLK transition
    a_r6_lead_moves_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        lead_pulse |-> (sclk != $past(sclk)));

    a_r6_trail_moves_sclk: assert property (@(posedge clk) disable iff (!rst_n)
        trail_pulse |-> (sclk != $past(sclk)));

    // R1: inside a frame SCLK only moves on a strobed edge
    a_r1_edge_has_strobe: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_active && $past(frame_active) && (sclk != $past(sclk)))
            |-> (lead_pulse || trail_pulse));

    // R7: a low enable never produces a new leading edge
    a_r7_no_lead_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !lead_pulse);

endmodule

bind spi_sclk_gen spi_sclk_gen_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .en           (en),
    .sclk         (sclk),
    .lead_pulse   (lead_pulse),
    .trail_pulse  (trail_pulse),
    .frame_active (frame_active)
);

// File: tb/spi_sclk_gen_tb_top.sv
module spi_sclk_gen_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 200000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       run = 1'b0;
    logic       cpol = 1'b0;
    logic [7:0] prescale = 8'd2;
    logic [7:0] rate = 8'd0;
    logic       sclk, lead_pulse, trail_pulse;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    spi_sclk_gen dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .en          (en),
        .prescale    (prescale),
        .rate        (rate),
        .cpol        (cpol),
        .run         (run),
        .sclk        (sclk),
        .lead_pulse  (lead_pulse),
        .trail_pulse (trail_pulse)
    );

    function automatic int exp_half(input int pre, input int rt);
        int p;
        p = pre / 2;
        if (p == 0) p = 1;
        return p * (rt + 1);
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Count negedges until the chosen strobe is seen; -1 on timeout.
    task automatic wait_strobe(input bit want_lead, input int limit, output int cnt);
        cnt = 0;
        forever begin
            @(negedge clk);
            cnt++;
            if (want_lead ? lead_pulse : trail_pulse) return;
            if (cnt >= limit) begin
                cnt = -1;
                return;
            end
        end
    endtask

    // Quiet window: no strobes and SCLK at the polarity input.
    task automatic quiet_window(input int len, input string req);
        bit ok = 1'b1;
        int bad = 0;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (lead_pulse || trail_pulse || (sclk != cpol)) begin
                ok = 1'b0;
                bad = i;
            end
        end
        check(ok, req, bad, -1);
    endtask

    task automatic frame_test(input int pre, input int rt, input bit pol);
        int h, c, h2;
        @(negedge clk);
        prescale = pre[7:0]; rate = rt[7:0]; cpol = pol; en = 1'b1; run = 1'b1;
        h = exp_half(pre, rt);
        wait_strobe(1'b1, 4*h + 10, c);
        check(c == h + 1, "R5 first lead delay", c, h + 1);
        check(sclk == !pol, "R6 level at lead", sclk, !pol);
        wait_strobe(1'b0, 4*h + 10, c);
        check(c == h, "R1 lead to trail", c, h);
        check(sclk == pol, "R6 level at trail", sclk, pol);
        wait_strobe(1'b1, 4*h + 10, c);
        check(c == h, "R1 trail to lead", c, h);
        // Mid-frame change: old divider and polarity must hold.
        prescale = 8'd2; rate = 8'd0; cpol = !pol;
        wait_strobe(1'b0, 4*h + 10, c);
        check(c == h, "R8 mid-frame change ignored", c, h);
        check(sclk == pol, "R8 polarity held", sclk, pol);
        run = 1'b0;
        quiet_window(2*h + 4, "R7 stop after run drop");
        // Next frame picks up the new values (half = 1).
        run = 1'b1;
        h2 = exp_half(2, 0);
        wait_strobe(1'b1, 20, c);
        check(c == h2 + 1, "R8 new frame uses new values", c, h2 + 1);
        run = 1'b0;
        wait_strobe(1'b0, 20, c);
        check(c == h2, "R7 trail completes after stop", c, h2);
        quiet_window(4, "R4 idle after frame");
    endtask

    initial begin
        int c;
        void'($urandom(32'd20240611));
        // Reset state.
        cpol = 1'b1;
        repeat (3) @(negedge clk);
        check(sclk == 1'b1, "R4 idle high in reset", sclk, 1);
        check(!lead_pulse && !trail_pulse, "R4 strobes low in reset",
              lead_pulse + trail_pulse, 0);
        rst_n = 1'b1;
        cpol = 1'b0;
        @(negedge clk);
        check(sclk == 1'b0, "R4 idle low after reset", sclk, 0);

        // Idle with enable but no run, then run without enable.
        en = 1'b1; run = 1'b0;
        for (int i = 0; i < 4; i++) begin
            cpol = i[0];
            quiet_window(10, "R7 no run no toggle");
        end
        en = 1'b0; run = 1'b1;
        quiet_window(40, "R7 disabled no toggle");
        run = 1'b0;

        // Quarter-rate directed case with pulse width check.
        @(negedge clk);
        prescale = 8'd2; rate = 8'd1; cpol = 1'b0; en = 1'b1; run = 1'b1;
        wait_strobe(1'b1, 40, c);
        check(c == 3, "R2 quarter first lead", c, 3);
        @(negedge clk);
        check(!lead_pulse, "R6 lead lasts one cycle", lead_pulse, 0);
        wait_strobe(1'b1, 40, c);
        check(c == 3, "R2 quarter period", c + 1, 4);
        run = 1'b0;
        wait_strobe(1'b0, 40, c);
        quiet_window(8, "R7 quarter stop");

        // Rounding and clamping of the prescale.
        frame_test(0, 0, 1'b0);   // R3 zero acts as two
        frame_test(1, 2, 1'b1);   // R3 one acts as two
        frame_test(3, 2, 1'b0);   // R3 odd rounds down
        frame_test(255, 0, 1'b1); // R3 top odd value
        frame_test(2, 1, 1'b1);   // R2 at high polarity

        // Enable drop mid-frame while SCLK is away from idle.
        @(negedge clk);
        prescale = 8'd4; rate = 8'd1; cpol = 1'b0; en = 1'b1; run = 1'b1;
        wait_strobe(1'b1, 40, c);
        en = 1'b0;
        wait_strobe(1'b0, 40, c);
        check(c == 4, "R7 trail after enable drop", c, 4);
        quiet_window(20, "R7 no lead after enable drop");
        run = 1'b0;

        // Wide counters: large prescale and rate.
        @(negedge clk);
        prescale = 8'd254; rate = 8'd127; cpol = 1'b0; en = 1'b1; run = 1'b1;
        wait_strobe(1'b1, 40000, c);
        check(c == exp_half(254, 127) + 1, "R1 large divider first lead",
              c, exp_half(254, 127) + 1);
        run = 1'b0;
        wait_strobe(1'b0, 40000, c);
        check(c == exp_half(254, 127), "R1 large divider half period",
              c, exp_half(254, 127));
        quiet_window(4, "R4 idle after large frame");

        // Random frames.
        for (int k = 0; k < 8; k++) begin
            int p, r;
            p = int'($urandom_range(0, 255));
            r = int'($urandom_range(0, 7));
            frame_test(p, r, k[0]);
        end

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (MAX_CYCLES) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=0", MAX_CYCLES);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule